// File: doc/BRIEF.md
# Power-Management Event Status and Timer Unit

This block keeps the power-management event status and event enable registers of a system, together with a free-running power-management timer. Software reaches the registers through a small byte-addressed port. The port has one write strobe and a read path that returns data with no side effects. The status register collects three kinds of event:

- overflow of the timer's top bit;
- power-button requests from the platform;
- wake events, each tagged with its cause.

Software clears status bits by writing ones to them.

The block drives a level system-control interrupt. The interrupt is high while any enabled status bit in the common-event group is set, or while an external general-purpose-event pending input is high. The timer advances once on every cycle in which a tick-enable input is high, so the surrounding design decides the timer rate.

Top module: `pm_event_timer`

## Requirements
- R1: Reads return data combinationally from `bus_addr`: offset 0 returns the status register in bits 15:0, offset 2 returns the enable register in bits 15:0, and offset 8 returns the timer count zero-extended to 32 bits. Every other offset reads as zero, and a write to any other offset changes nothing.
- R2: A write to offset 0 clears exactly the status bits whose `bus_wdata` bit is 1. When an event sets a bit in the same cycle that the write clears it, the bit ends up set.
- R3: The timer is `TMR_W` bits wide (24 by default). It increments by one on each clock edge where `tick_en` is high and wraps modulo 2^`TMR_W`. A write to offset 8 has no effect on it.
- R4: Status bit 0 (timer) becomes set on the edge where the timer's most significant bit changes value. This covers the change from 0 to 1 and the wrap from all ones back to zero.
- R5: A `pwrbtn_req` pulse sets status bit 8 (power button) only if enable bit 8 is set. Otherwise the pulse leaves the status unchanged.
- R6: A `wake_req` pulse sets status bit 15 (wake) regardless of the enables. It also sets a cause bit selected by `wake_cause`: 0 sets bit 10 (RTC), 1 sets bit 0 (timer), and 2 or 3 set bit 8 (power button).
- R7: `sci` is high exactly when (status AND enable AND 16'h0721) is nonzero, or when `gpe_pending` is high. The mask 16'h0721 covers bits 0, 5, 8, 9 and 10, so status bit 15 alone never raises `sci`.
- R8: While `rst_n` is low, the status register, the enable register and the timer are all held at zero.
- R9: A write to offset 2 replaces all 16 enable bits with `bus_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer advance enable, one tick per high cycle |
| bus_addr | input | ADDR_W (4) | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pwrbtn_req | input | 1 | Power-button request pulse |
| wake_req | input | 1 | Wake event pulse |
| wake_cause | input | 2 | Wake cause: 0 RTC, 1 timer, 2 or 3 other |
| gpe_pending | input | 1 | External general-purpose-event pending level |
| sci | output | 1 | Level system-control interrupt |

## Verification
The write-clear and power-button gating properties assume that no other event arrives in the same cycle. The bench meets this by applying each event pulse, bus write and tick burst in its own cycles, except in the one scenario that deliberately overlaps a wake event with a status write. The bench runs the timer with `TMR_W` set to 12, so that overflow and wrap happen within a short run. It tracks the tick count itself and never writes the timer except to show that the write is ignored.

// File: rtl/pmev_pkg.sv
package pmev_pkg;

    localparam int STS_W    = 16;
    localparam int B_TMR    = 0;
    localparam int B_GBL    = 5;
    localparam int B_PWRBTN = 8;
    localparam int B_SLPBTN = 9;
    localparam int B_RTC    = 10;
    localparam int B_WAKE   = 15;

    localparam logic [STS_W-1:0] COMMON_MASK =
        STS_W'((1 << B_TMR) | (1 << B_GBL) | (1 << B_PWRBTN) |
               (1 << B_SLPBTN) | (1 << B_RTC));

    localparam int OFF_STS = 0;
    localparam int OFF_EN  = 2;
    localparam int OFF_TMR = 8;

    typedef enum logic [1:0] {
        WAKE_RTC   = 2'd0,
        WAKE_TIMER = 2'd1,
        WAKE_OTH_A = 2'd2,
        WAKE_OTH_B = 2'd3
    } wake_cause_e;

    typedef struct packed {
        logic [STS_W-1:0] sts;
        logic [STS_W-1:0] en;
    } evt_state_t;

endpackage

// File: rtl/pm_timer.sv
module pm_timer #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [TMR_W-1:0] cnt_q,
    output logic             ovf
);
    localparam logic [TMR_W-2:0] LOW_ONES = '1;

    logic [TMR_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (tick_en) begin
            cnt_d = cnt_q + TMR_W'(1);
        end
    end

    // top bit changes exactly when the lower bits roll over on a tick
    assign ovf = tick_en && (cnt_q[TMR_W-2:0] == LOW_ONES);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/pm_event_set.sv
module pm_event_set
    import pmev_pkg::*;
(
    input  logic             tmr_ovf,
    input  logic             pwrbtn_req,
    input  logic             pwrbtn_en,
    input  logic             wake_req,
    input  logic [1:0]       wake_cause,
    output logic [STS_W-1:0] set_vec
);
    wake_cause_e cause;
    assign cause = wake_cause_e'(wake_cause);

    always_comb begin
        set_vec = '0;
        if (tmr_ovf) begin
            set_vec[B_TMR] = 1'b1;
        end
        if (pwrbtn_req && pwrbtn_en) begin
            set_vec[B_PWRBTN] = 1'b1;
        end
        if (wake_req) begin
            set_vec[B_WAKE] = 1'b1;
            unique case (cause)
                WAKE_RTC:   set_vec[B_RTC]    = 1'b1;
                WAKE_TIMER: set_vec[B_TMR]    = 1'b1;
                default:    set_vec[B_PWRBTN] = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
    import pmev_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STS_W-1:0] set_vec,
    input  logic             wr_sts,
    input  logic             wr_en,
    input  logic [STS_W-1:0] wdata,
    input  logic             gpe_pending,
    output logic [STS_W-1:0] sts_q,
    output logic [STS_W-1:0] en_q,
    output logic             sci
);
    evt_state_t st_d, st_q;
    logic [STS_W-1:0] clr_vec;

    always_comb begin
        clr_vec = wr_sts ? wdata : '0;
        st_d    = st_q;
        // events win over a clear of the same bit
        st_d.sts = (st_q.sts & ~clr_vec) | set_vec;
        if (wr_en) begin
            st_d.en = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sts_q = st_q.sts;
    assign en_q  = st_q.en;
    assign sci   = (|(st_q.sts & st_q.en & COMMON_MASK)) || gpe_pending;
endmodule

// File: rtl/pm_reg_read.sv
module pm_reg_read
    import pmev_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int TMR_W  = 24,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [STS_W-1:0]  sts,
    input  logic [STS_W-1:0]  en,
    input  logic [TMR_W-1:0]  cnt,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFF_STS)) begin
            rdata = DATA_W'(sts);
        end else if (addr == ADDR_W'(OFF_EN)) begin
            rdata = DATA_W'(en);
        end else if (addr == ADDR_W'(OFF_TMR)) begin
            rdata = DATA_W'(cnt);
        end
    end
endmodule

// File: rtl/pm_event_timer.sv
module pm_event_timer
    import pmev_pkg::*;
#(
    parameter int TMR_W  = 24,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [15:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              pwrbtn_req,
    input  logic              wake_req,
    input  logic [1:0]        wake_cause,
    input  logic              gpe_pending,
    output logic              sci
);
    localparam int DATA_W = 32;

    logic [TMR_W-1:0] cnt_q;
    logic             tmr_ovf;
    logic [STS_W-1:0] set_vec;
    logic [STS_W-1:0] sts_q;
    logic [STS_W-1:0] en_q;
    logic             wr_sts;
    logic             wr_en;

    assign wr_sts = bus_wr && (bus_addr == ADDR_W'(OFF_STS));
    assign wr_en  = bus_wr && (bus_addr == ADDR_W'(OFF_EN));

    pm_timer #(.TMR_W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .cnt_q   (cnt_q),
        .ovf     (tmr_ovf)
    );

    pm_event_set u_set (
        .tmr_ovf    (tmr_ovf),
        .pwrbtn_req (pwrbtn_req),
        .pwrbtn_en  (en_q[B_PWRBTN]),
        .wake_req   (wake_req),
        .wake_cause (wake_cause),
        .set_vec    (set_vec)
    );

    pm_evt_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_vec     (set_vec),
        .wr_sts      (wr_sts),
        .wr_en       (wr_en),
        .wdata       (bus_wdata),
        .gpe_pending (gpe_pending),
        .sts_q       (sts_q),
        .en_q        (en_q),
        .sci         (sci)
    );

    pm_reg_read #(
        .ADDR_W (ADDR_W),
        .TMR_W  (TMR_W),
        .DATA_W (DATA_W)
    ) u_read (
        .addr  (bus_addr),
        .sts   (sts_q),
        .en    (en_q),
        .cnt   (cnt_q),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/pm_event_timer_chk.sv
module pm_event_timer_chk
    import pmev_pkg::*;
#(
    parameter int TMR_W  = 24,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [15:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              pwrbtn_req,
    input logic              wake_req,
    input logic              gpe_pending,
    input logic              sci,
    input logic [15:0]       sts_q,
    input logic [15:0]       en_q,
    input logic [TMR_W-1:0]  cnt_q
);
    logic mapped;
    assign mapped = (bus_addr == ADDR_W'(OFF_STS)) || (bus_addr == ADDR_W'(OFF_EN)) ||
                    (bus_addr == ADDR_W'(OFF_TMR));

    p_rd_unmapped_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> bus_rdata == 32'd0);

    p_wr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_STS) && !pwrbtn_req && !wake_req && !tick_en)
        |=> sts_q == ($past(sts_q) & ~$past(bus_wdata)));

    p_tmr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> cnt_q == $past(cnt_q));

    p_tmr_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q[TMR_W-1] != $past(cnt_q[TMR_W-1])) |-> sts_q[B_TMR]);

    p_pwrbtn_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrbtn_req && en_q[B_PWRBTN]) |=> sts_q[B_PWRBTN]);

    p_pwrbtn_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrbtn_req && !en_q[B_PWRBTN] && !wake_req && !bus_wr)
        |=> sts_q[B_PWRBTN] == $past(sts_q[B_PWRBTN]));

    p_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> sts_q[B_WAKE]);

    p_gpe_sci_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gpe_pending |-> sci);

    p_sci_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_q & COMMON_MASK) == 16'd0 && !gpe_pending) |-> !sci);

    p_en_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_EN)) |=> en_q == $past(bus_wdata));
endmodule

bind pm_event_timer pm_event_timer_chk #(.TMR_W(TMR_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pwrbtn_req  (pwrbtn_req),
    .wake_req    (wake_req),
    .gpe_pending (gpe_pending),
    .sci         (sci),
    .sts_q       (sts_q),
    .en_q        (en_q),
    .cnt_q       (cnt_q)
);

// File: tb/pm_event_timer_tb.sv
module pm_event_timer_tb;
    localparam int TW = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwrbtn_req = 1'b0;
    logic        wake_req = 1'b0;
    logic [1:0]  wake_cause = '0;
    logic        gpe_pending = 1'b0;
    logic        sci;

    int errors = 0;
    int checks = 0;
    int exp_cnt = 0;

    always #2 clk = ~clk;

    pm_event_timer #(.TMR_W(TW), .ADDR_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwrbtn_req(pwrbtn_req), .wake_req(wake_req), .wake_cause(wake_cause),
        .gpe_pending(gpe_pending), .sci(sci)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
        exp_cnt = (exp_cnt + n) % (1 << TW);
    endtask

    task automatic pulse_wake(input logic [1:0] c);
        @(negedge clk);
        wake_req = 1'b1; wake_cause = c;
        @(negedge clk);
        wake_req = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(4'd0, d); check("R8 status after reset", d, 32'h0);
        rd(4'd2, d); check("R8 enable after reset", d, 32'h0);
        rd(4'd8, d); check("R8 timer after reset", d, 32'h0);
        check("R8 sci after reset", {31'd0, sci}, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        wr(4'd2, 16'hFFFF); rd(4'd2, d); check("R9 enable all ones", d, 32'h0000FFFF);
        wr(4'd2, 16'h5A3C); rd(4'd2, d); check("R9 enable replaced", d, 32'h00005A3C);
        wr(4'd2, 16'h0000); rd(4'd2, d); check("R9 enable zero", d, 32'h0);
    endtask

    task automatic t_timer_ro();
        logic [31:0] d;
        ticks(5); rd(4'd8, d); check("R3 timer counts ticks", d, 32'(exp_cnt));
        wr(4'd8, 16'h0123); rd(4'd8, d); check("R3 timer write ignored", d, 32'(exp_cnt));
        repeat (3) @(negedge clk);
        rd(4'd8, d); check("R3 timer holds without tick", d, 32'(exp_cnt));
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        wr(4'd0, 16'hFFFF);
        ticks((1 << (TW - 1)) - 1 - exp_cnt);
        rd(4'd0, d); check("R4 no overflow before msb change", d, 32'h0);
        ticks(1);
        rd(4'd8, d); check("R3 timer at half range", d, 32'(1 << (TW - 1)));
        rd(4'd0, d); check("R4 overflow on msb rise", d, 32'h0001);
        wr(4'd2, 16'h0001);
        check("R7 sci from timer status", {31'd0, sci}, 32'h1);
        wr(4'd2, 16'h0000);
        wr(4'd0, 16'h0001);
        ticks((1 << TW) - 1 - exp_cnt);
        rd(4'd0, d); check("R4 no overflow at all ones", d, 32'h0);
        ticks(1);
        rd(4'd8, d); check("R3 timer wraps", d, 32'h0);
        rd(4'd0, d); check("R4 overflow on wrap", d, 32'h0001);
        wr(4'd0, 16'hFFFF);
    endtask

    task automatic t_pwrbtn();
        logic [31:0] d;
        wr(4'd2, 16'h0000);
        @(negedge clk); pwrbtn_req = 1'b1; @(negedge clk); pwrbtn_req = 1'b0;
        rd(4'd0, d); check("R5 button ignored when disabled", d, 32'h0);
        wr(4'd2, 16'h0100);
        @(negedge clk); pwrbtn_req = 1'b1; @(negedge clk); pwrbtn_req = 1'b0;
        rd(4'd0, d); check("R5 button sets status", d, 32'h0100);
        check("R7 sci from button", {31'd0, sci}, 32'h1);
        wr(4'd0, 16'h0100);
        check("R7 sci drops after clear", {31'd0, sci}, 32'h0);
        wr(4'd2, 16'h0000);
    endtask

    task automatic t_wake();
        logic [31:0] d;
        pulse_wake(2'd0); rd(4'd0, d); check("R6 wake rtc", d, 32'h8400);
        wr(4'd0, 16'h0400); rd(4'd0, d); check("R2 partial clear", d, 32'h8000);
        wr(4'd2, 16'h8000);
        check("R7 wake bit outside mask", {31'd0, sci}, 32'h0);
        gpe_pending = 1'b1; #1;
        check("R7 gpe raises sci", {31'd0, sci}, 32'h1);
        gpe_pending = 1'b0; #1;
        wr(4'd2, 16'h0000);
        wr(4'd0, 16'hFFFF); rd(4'd0, d); check("R2 full clear", d, 32'h0);
        pulse_wake(2'd1); rd(4'd0, d); check("R6 wake timer", d, 32'h8001);
        wr(4'd0, 16'hFFFF);
        pulse_wake(2'd2); rd(4'd0, d); check("R6 wake other 2", d, 32'h8100);
        wr(4'd0, 16'hFFFF);
        pulse_wake(2'd3); rd(4'd0, d); check("R6 wake other 3", d, 32'h8100);
        wr(4'd0, 16'hFFFF);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        @(negedge clk);
        bus_addr = 4'd0; bus_wdata = 16'h8400; bus_wr = 1'b1;
        wake_req = 1'b1; wake_cause = 2'd0;
        @(negedge clk);
        bus_wr = 1'b0; wake_req = 1'b0;
        rd(4'd0, d); check("R2 set wins over clear", d, 32'h8400);
        wr(4'd0, 16'hFFFF);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(4'd2, 16'h0321);
        pulse_wake(2'd0);
        wr(4'd4, 16'hFFFF);
        rd(4'd0, d); check("R1 write to other offset ignored status", d, 32'h8400);
        rd(4'd2, d); check("R1 write to other offset ignored enable", d, 32'h0321);
        rd(4'd4, d); check("R1 offset 4 reads zero", d, 32'h0);
        rd(4'd1, d); check("R1 offset 1 reads zero", d, 32'h0);
        rd(4'd12, d); check("R1 offset 12 reads zero", d, 32'h0);
    endtask

    task automatic t_reset_mid();
        logic [31:0] d;
        ticks(7);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rd(4'd0, d); check("R8 status cleared by reset", d, 32'h0);
        rd(4'd2, d); check("R8 enable cleared by reset", d, 32'h0);
        rd(4'd8, d); check("R8 timer cleared by reset", d, 32'h0);
        rst_n = 1'b1;
        exp_cnt = 0;
    endtask

    initial begin
        #(4 * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_timer_ro();
        t_overflow();
        t_pwrbtn();
        t_wake();
        t_set_wins();
        t_unmapped();
        t_reset_mid();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule